// File: doc/BRIEF.md
# Command-word I2C master engine

This block is the bus-facing half of an I2C controller. It consumes a stream of 11-bit command words from an external command queue. Each word asks for one byte on the bus: either a byte to write, or a placeholder that asks the engine to read one byte from the target. Two flag bits in the same word ask for a repeated START before the byte or a STOP after it. Because every word carries its own framing, one queue can describe a whole multi-message transfer. Bytes that are read go out one at a time to an external receive queue.

The engine drives open-drain SCL and SDA through two "pull low" outputs and reads the resolved SDA level back. Bit timing comes from a separate divider, which pulses `tick` once per quarter of an SCL period. Each bus primitive (START, repeated START, STOP, one data bit) takes four ticks. The target address and the 7/10-bit mode are static inputs. A completion pulse ends every transfer. An error pulse comes before it when the target refuses a byte.

Top module: `i2c_cw_master`

## Requirements
- R1: A command word holds write data in bits 7:0, the read request in bit 8, the stop request in bit 9 and the repeated-start request in bit 10. A write command sends its data byte MSB first and then samples the acknowledge bit, where SDA low means ACK.
- R2: A command with bit 8 set clocks one byte in from the target while SDA is released, and its bits 7:0 have no effect on the bus. Each received byte appears on `rx_byte` with a one-cycle `rx_push`, one per read command and in command order.
- R3: In 7-bit mode (`addr_10b`=0) the address phase is one byte: `tgt_addr[6:0]` followed by R/W. R/W is 1 if the command that opens the phase is a read and 0 otherwise.
- R4: In 10-bit mode (`addr_10b`=1) the address phase is two bytes. The first is binary 11110, then `tgt_addr[9:8]`, then R/W. The second is `tgt_addr[7:0]`.
- R5: A command other than the first of a transfer that has bit 10 set causes a repeated START and a new address phase, with that command's direction, before its byte.
- R6: After the byte of a command with bit 9 set, the engine issues a STOP. It then pulses `xfer_done` for one cycle with both bus lines released.
- R7: After a read byte the engine drives ACK (SDA low) in the acknowledge slot. After the read byte of a stop-flagged command it leaves SDA high (NACK).
- R8: A NACK on an address byte or on a written byte pulses `xfer_err`, issues a STOP, and discards the queued commands up to and including the next stop-flagged one (none if the current command has the flag). It then pulses `xfer_done`, always after `xfer_err`.
- R9: If the command queue is empty after a byte that had no stop request, SCL is held low and nothing happens on the bus until a command arrives. A command is popped only when the queue is not empty.
- R10: After reset both lines are released. Outside START, repeated START and STOP, SDA changes only while SCL is low.
- R11: The repeated-start flag on the first command of a transfer has no effect: the bus shows a single START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Quarter-bit timing strobe from the divider |
| tgt_addr | input | ADDR_W | Target address |
| addr_10b | input | 1 | 1 selects 10-bit addressing |
| cmd_word | input | 11 | Head entry of the command queue |
| cmd_empty | input | 1 | Command queue holds no entry |
| cmd_pop | output | 1 | Removes the head entry (one-cycle pulse) |
| rx_push | output | 1 | Writes `rx_byte` into the receive queue |
| rx_byte | output | 8 | Received byte |
| sda_in | input | 1 | Resolved SDA level |
| scl_low | output | 1 | 1 pulls SCL low |
| sda_low | output | 1 | 1 pulls SDA low |
| xfer_done | output | 1 | Transfer-complete pulse |
| xfer_err | output | 1 | Target NACK pulse |

## Verification
The bench tries the main path with several command streams: pure writes, pure reads with junk in the data field, a write followed by a restarted read, 10-bit addressing, and a restart flag on the opening command. Comparing the decoded bus events tells apart the address formats, the R/W choice, the ACK/NACK choice and single versus repeated START. Two NACK patterns, one on the address and one on a data byte, followed by a clean transfer, show whether the leftover commands were really discarded. A starved queue shows whether SCL is parked low without stray bus activity.

// File: rtl/i2c_cw_pkg.sv
package i2c_cw_pkg;
   localparam int CW_RD    = 8;
   localparam int CW_STOP  = 9;
   localparam int CW_RSTRT = 10;
   localparam int CW_W     = 11;
   localparam int BYTE_W   = 8;

   typedef enum logic [1:0] {
      PH_START,
      PH_RESTART,
      PH_STOP,
      PH_BIT
   } phy_op_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_START,
      SQ_ADDR,
      SQ_DATA,
      SQ_RESTART,
      SQ_WAIT,
      SQ_STOP,
      SQ_FLUSH
   } seq_st_e;
endpackage

// File: rtl/i2c_cw_bitphy.sv
module i2c_cw_bitphy
   import i2c_cw_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tick,
   input  logic    go,
   input  phy_op_e op,
   input  logic    bit_val,
   input  logic    sda_in,
   output logic    busy,
   output logic    done,
   output logic    rx_bit,
   output logic    scl_low,
   output logic    sda_low
);
   localparam int PH_W = 2;
   localparam logic [PH_W-1:0] PH_LAST = '1;

   phy_op_e         op_q;
   logic            bit_q;
   logic [PH_W-1:0] phase;

   // returns {scl_low, sda_low} for a quarter of a primitive
   function automatic logic [1:0] drive_f(phy_op_e o, logic [PH_W-1:0] p, logic b);
      logic [1:0] r;
      case (o)
         PH_START:   r = p[1] ? 2'b11 : 2'b01;
         PH_RESTART: begin
            case (p)
               2'd0:    r = 2'b10;
               2'd1:    r = 2'b00;
               2'd2:    r = 2'b01;
               default: r = 2'b11;
            endcase
         end
         PH_STOP: begin
            case (p)
               2'd0:    r = 2'b11;
               2'd1:    r = 2'b01;
               default: r = 2'b00;
            endcase
         end
         default:    r = {(p == 2'd0) || (p == 2'd3), ~b};
      endcase
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= PH_BIT;
         bit_q   <= 1'b1;
         phase   <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
         rx_bit  <= 1'b1;
         scl_low <= 1'b0;
         sda_low <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go && !busy) begin
            op_q               <= op;
            bit_q              <= bit_val;
            phase              <= '0;
            busy               <= 1'b1;
            {scl_low, sda_low} <= drive_f(op, '0, bit_val);
         end else if (busy && tick) begin
            if (phase == 2'd2) rx_bit <= sda_in;
            if (phase == PH_LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               phase              <= phase + 2'd1;
               {scl_low, sda_low} <= drive_f(op_q, phase + 2'd1, bit_q);
            end
         end
      end
   end

   // R10
   sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q == PH_BIT && !scl_low && !$past(scl_low)) |-> $stable(sda_low));

   // R6
   stop_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_low && !$past(scl_low) && $past(sda_low) && !sda_low) |-> (op_q == PH_STOP));
endmodule

// File: rtl/i2c_cw_addrgen.sv
module i2c_cw_addrgen #(
   parameter int ADDR_W    = 10,
   parameter bit ADDR10_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              mode10,
   input  logic              rw,
   output logic [7:0]        hdr0,
   output logic [7:0]        hdr1,
   output logic              two_byte
);
   if (ADDR_W < 7) begin : g_bad_w
      $error("i2c_cw_addrgen: ADDR_W must be at least 7");
   end
   if (ADDR10_EN && ADDR_W < 10) begin : g_bad_10
      $error("i2c_cw_addrgen: 10-bit mode needs ADDR_W of at least 10");
   end

   if (ADDR10_EN) begin : g_ten
      localparam logic [4:0] TEN_PFX = 5'b11110;
      assign two_byte = mode10;
      assign hdr0     = mode10 ? {TEN_PFX, tgt_addr[9:8], rw} : {tgt_addr[6:0], rw};
      assign hdr1     = tgt_addr[7:0];
   end else begin : g_seven
      logic unused_mode;
      assign unused_mode = mode10;
      assign two_byte    = 1'b0;
      assign hdr0        = {tgt_addr[6:0], rw};
      assign hdr1        = 8'h00;
   end
endmodule

// File: rtl/i2c_cw_seq.sv
module i2c_cw_seq
   import i2c_cw_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CW_W-1:0] cmd_word,
   input  logic            cmd_empty,
   output logic            cmd_pop,
   input  logic [7:0]      hdr0,
   input  logic [7:0]      hdr1,
   input  logic            two_byte,
   output logic            cur_rw,
   output logic            phy_go,
   output phy_op_e         phy_op,
   output logic            phy_bit,
   input  logic            phy_busy,
   input  logic            phy_done,
   input  logic            phy_rx,
   input  logic            scl_low_i,
   input  logic            sda_low_i,
   output logic            rx_push,
   output logic [7:0]      rx_byte,
   output logic            xfer_done,
   output logic            xfer_err
);
   localparam int BN_W = $clog2(BYTE_W + 1);
   localparam logic [BN_W-1:0] ACK_SLOT = BN_W'(BYTE_W);

   seq_st_e         st;
   logic [CW_W-1:0] cur;
   logic [7:0]      sh, rxs;
   logic [BN_W-1:0] bitn;
   logic            second, waiting, abort_q;
   logic            rx_byte_c, bit_c, active_c;
   phy_op_e         op_c;

   assign cur_rw    = cur[CW_RD];
   assign rx_byte_c = (st == SQ_DATA) && cur[CW_RD];

   always_comb begin
      if (bitn == ACK_SLOT) bit_c = rx_byte_c ? cur[CW_STOP] : 1'b1;
      else                  bit_c = rx_byte_c ? 1'b1 : sh[7];
      case (st)
         SQ_START:   op_c = PH_START;
         SQ_RESTART: op_c = PH_RESTART;
         SQ_STOP:    op_c = PH_STOP;
         default:    op_c = PH_BIT;
      endcase
      active_c = (st == SQ_START) || (st == SQ_RESTART) || (st == SQ_STOP) ||
                 (st == SQ_ADDR)  || (st == SQ_DATA);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         cur       <= '0;
         sh        <= '0;
         rxs       <= '0;
         bitn      <= '0;
         second    <= 1'b0;
         waiting   <= 1'b0;
         abort_q   <= 1'b0;
         cmd_pop   <= 1'b0;
         phy_go    <= 1'b0;
         phy_op    <= PH_BIT;
         phy_bit   <= 1'b1;
         rx_push   <= 1'b0;
         rx_byte   <= '0;
         xfer_done <= 1'b0;
         xfer_err  <= 1'b0;
      end else begin
         cmd_pop   <= 1'b0;
         phy_go    <= 1'b0;
         rx_push   <= 1'b0;
         xfer_done <= 1'b0;
         xfer_err  <= 1'b0;
         if (active_c && !waiting && !phy_busy) begin
            phy_go  <= 1'b1;
            phy_op  <= op_c;
            phy_bit <= bit_c;
            waiting <= 1'b1;
         end
         case (st)
            SQ_IDLE: begin
               if (!cmd_empty) begin
                  cur     <= cmd_word;
                  cmd_pop <= 1'b1;
                  abort_q <= 1'b0;
                  st      <= SQ_START;
               end
            end
            SQ_START, SQ_RESTART: begin
               if (waiting && phy_done) begin
                  waiting <= 1'b0;
                  sh      <= hdr0;
                  bitn    <= '0;
                  second  <= 1'b0;
                  st      <= SQ_ADDR;
               end
            end
            SQ_STOP: begin
               if (waiting && phy_done) begin
                  waiting <= 1'b0;
                  if (abort_q && !cur[CW_STOP]) begin
                     st <= SQ_FLUSH;
                  end else begin
                     xfer_done <= 1'b1;
                     st        <= SQ_IDLE;
                  end
               end
            end
            SQ_ADDR, SQ_DATA: begin
               if (waiting && phy_done) begin
                  waiting <= 1'b0;
                  if (bitn != ACK_SLOT) begin
                     sh   <= {sh[6:0], 1'b0};
                     rxs  <= {rxs[6:0], phy_rx};
                     bitn <= bitn + 1'b1;
                  end else begin
                     bitn <= '0;
                     if (st == SQ_ADDR) begin
                        if (phy_rx) begin
                           xfer_err <= 1'b1;
                           abort_q  <= 1'b1;
                           st       <= SQ_STOP;
                        end else if (two_byte && !second) begin
                           second <= 1'b1;
                           sh     <= hdr1;
                        end else begin
                           sh <= cur[7:0];
                           st <= SQ_DATA;
                        end
                     end else if (!cur[CW_RD] && phy_rx) begin
                        xfer_err <= 1'b1;
                        abort_q  <= 1'b1;
                        st       <= SQ_STOP;
                     end else begin
                        if (cur[CW_RD]) begin
                           rx_push <= 1'b1;
                           rx_byte <= rxs;
                        end
                        st <= cur[CW_STOP] ? SQ_STOP : SQ_WAIT;
                     end
                  end
               end
            end
            SQ_WAIT: begin
               if (!cmd_empty) begin
                  cur     <= cmd_word;
                  cmd_pop <= 1'b1;
                  if (cmd_word[CW_RSTRT]) begin
                     st <= SQ_RESTART;
                  end else begin
                     sh   <= cmd_word[7:0];
                     bitn <= '0;
                     st   <= SQ_DATA;
                  end
               end
            end
            default: begin
               if (!cmd_empty) begin
                  cmd_pop <= 1'b1;
                  if (cmd_word[CW_STOP]) begin
                     xfer_done <= 1'b1;
                     st        <= SQ_IDLE;
                  end
               end
            end
         endcase
      end
   end

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (!scl_low_i && !sda_low_i));

   // R8
   err_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |=> !xfer_done);

   // R9
   pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pop |-> !$past(cmd_empty));
endmodule

// File: rtl/i2c_cw_master.sv
module i2c_cw_master
   import i2c_cw_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter bit ADDR10_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              addr_10b,
   input  logic [CW_W-1:0]   cmd_word,
   input  logic              cmd_empty,
   output logic              cmd_pop,
   output logic              rx_push,
   output logic [7:0]        rx_byte,
   input  logic              sda_in,
   output logic              scl_low,
   output logic              sda_low,
   output logic              xfer_done,
   output logic              xfer_err
);
   logic       phy_go, phy_bit, phy_busy, phy_done, phy_rx, cur_rw, two_byte;
   phy_op_e    phy_op;
   logic [7:0] hdr0, hdr1;

   i2c_cw_addrgen #(.ADDR_W(ADDR_W), .ADDR10_EN(ADDR10_EN)) u_addr (
      .tgt_addr (tgt_addr),
      .mode10   (addr_10b),
      .rw       (cur_rw),
      .hdr0     (hdr0),
      .hdr1     (hdr1),
      .two_byte (two_byte)
   );

   i2c_cw_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_word  (cmd_word),
      .cmd_empty (cmd_empty),
      .cmd_pop   (cmd_pop),
      .hdr0      (hdr0),
      .hdr1      (hdr1),
      .two_byte  (two_byte),
      .cur_rw    (cur_rw),
      .phy_go    (phy_go),
      .phy_op    (phy_op),
      .phy_bit   (phy_bit),
      .phy_busy  (phy_busy),
      .phy_done  (phy_done),
      .phy_rx    (phy_rx),
      .scl_low_i (scl_low),
      .sda_low_i (sda_low),
      .rx_push   (rx_push),
      .rx_byte   (rx_byte),
      .xfer_done (xfer_done),
      .xfer_err  (xfer_err)
   );

   i2c_cw_bitphy u_phy (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .go      (phy_go),
      .op      (phy_op),
      .bit_val (phy_bit),
      .sda_in  (sda_in),
      .busy    (phy_busy),
      .done    (phy_done),
      .rx_bit  (phy_rx),
      .scl_low (scl_low),
      .sda_low (sda_low)
   );
endmodule

// File: tb/tb_i2c_cw_master.sv
module tb_i2c_cw_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [9:0]  tgt_addr = 10'h052;
   logic        addr_10b = 1'b0;
   logic [10:0] cmd_word;
   logic        cmd_empty;
   logic        cmd_pop, rx_push, scl_low, sda_low, xfer_done, xfer_err, sda_in;
   logic [7:0]  rx_byte;
   logic        slv_low = 1'b0;

   always #5 clk = ~clk;

   logic [10:0] cq [0:63];
   logic [5:0]  qh = '0, qt = '0;
   assign cmd_empty = (qh == qt);
   assign cmd_word  = cq[qh];

   wire scl_bus = !scl_low;
   wire sda_bus = !sda_low && !slv_low;
   assign sda_in = sda_bus;

   i2c_cw_master dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .tgt_addr(tgt_addr), .addr_10b(addr_10b),
      .cmd_word(cmd_word), .cmd_empty(cmd_empty), .cmd_pop(cmd_pop), .rx_push(rx_push),
      .rx_byte(rx_byte), .sda_in(sda_in), .scl_low(scl_low), .sda_low(sda_low),
      .xfer_done(xfer_done), .xfer_err(xfer_err)
   );

   int nchk = 0, nfail = 0;
   string tag = "R10";
   int ek [0:15];
   int ev [0:15];
   int en = 0, oi = 0;
   logic [7:0] erx [0:7];
   int ern = 0, ori = 0;
   logic [7:0] sdat [0:7];
   int sdi = 0, nack_at = -1;
   int errc = 0, donec = 0, err_at_done = 0;

   task automatic chk(input bit ok, input string t, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", t, act, exp);
      end
   endtask

   // observed bus event against expected list (kind 0 START, 1 STOP, 2 byte={data,ack})
   task automatic obs(input int k, input int v);
      if (oi >= en) chk(1'b0, {tag, " extra bus event"}, k * 1024 + v, -1);
      else chk(ek[oi] == k && ev[oi] == v, {tag, " bus event"}, k * 1024 + v, ek[oi] * 1024 + ev[oi]);
      oi++;
   endtask

   // behavioural target and bus monitor, sampled away from the active edge
   logic       p_scl = 1'b1, p_sda = 1'b1, in_fr = 1'b0, rd_dir = 1'b0, rd_end = 1'b0;
   logic [8:0] shf = '0;
   int         bitc = 0, bytec = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         automatic logic s_scl = scl_bus;
         automatic logic s_sda = sda_bus;
         automatic int   naddr = addr_10b ? 2 : 1;
         if (s_scl && p_scl && p_sda && !s_sda) begin
            obs(0, 0);
            in_fr = 1'b1; bitc = 0; bytec = 0; rd_dir = 1'b0; rd_end = 1'b0; slv_low = 1'b0;
         end else if (s_scl && p_scl && !p_sda && s_sda) begin
            obs(1, 0);
            in_fr = 1'b0; slv_low = 1'b0;
         end else if (in_fr && s_scl && !p_scl) begin
            shf = {shf[7:0], s_sda};
            bitc++;
            if (bitc == 9) begin
               obs(2, int'(shf));
               if (bytec == 0) rd_dir = shf[1];
               if (bytec >= naddr && rd_dir) begin
                  sdi++;
                  if (shf[0]) rd_end = 1'b1;
               end
               bytec++;
               bitc = 0;
            end
         end else if (in_fr && !s_scl && p_scl) begin
            if (bitc == 8) begin
               if (bytec >= naddr && rd_dir) slv_low = 1'b0;
               else slv_low = (bytec != nack_at);
            end else if (bytec >= naddr && rd_dir && !rd_end) begin
               slv_low = !sdat[sdi][7 - bitc];
            end else begin
               slv_low = 1'b0;
            end
         end
         p_scl = s_scl;
         p_sda = s_sda;
         if (cmd_pop) qh = qh + 1'b1;
         if (rx_push) begin
            // R2
            chk(ori < ern && rx_byte == erx[ori], {tag, " R2 rx byte"}, int'(rx_byte), ori < ern ? int'(erx[ori]) : -1);
            ori++;
         end
         if (xfer_err) errc++;
         if (xfer_done) begin
            donec++;
            err_at_done = errc;
         end
      end
   end

   initial begin
      int tc = 0;
      forever begin
         @(negedge clk);
         tc = (tc + 1) % 4;
         tick = (tc == 0);
      end
   end

   task automatic exp_ev(input int k, input int v);
      ek[en] = k; ev[en] = v; en++;
   endtask

   function automatic int bt(input logic [7:0] b, input logic a);
      return int'({b, a});
   endfunction

   task automatic push_cmd(input logic [10:0] w);
      cq[qt] = w;
      qt = qt + 1'b1;
   endtask

   task automatic new_case(input string t);
      tag = t; en = 0; oi = 0; ern = 0; ori = 0; sdi = 0; nack_at = -1;
      errc = 0; donec = 0; err_at_done = 0;
   endtask

   task automatic end_case(input int exp_err);
      int lim = 0;
      while (donec == 0 && lim < 8000) begin
         @(negedge clk);
         lim++;
      end
      repeat (40) @(negedge clk);
      chk(donec == 1, {tag, " R6 done pulses"}, donec, 1);
      chk(oi == en, {tag, " bus event count"}, oi, en);
      chk(ori == ern, {tag, " R2 rx count"}, ori, ern);
      chk(errc == exp_err, {tag, " R8 err pulses"}, errc, exp_err);
      if (exp_err != 0) chk(err_at_done == exp_err, {tag, " R8 err before done"}, err_at_done, exp_err);
      chk(qh == qt, {tag, " R8 queue drained"}, int'(qh), int'(qt));
      chk(!scl_low && !sda_low, {tag, " R10 bus idle"}, {scl_low, sda_low}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: released bus and quiet outputs after reset
      chk(!scl_low && !sda_low, "R10 reset bus", {scl_low, sda_low}, 0);
      chk(!cmd_pop && !rx_push && !xfer_done && !xfer_err, "R10 reset pulses",
          {cmd_pop, rx_push, xfer_done, xfer_err}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 R3 R6: two writes, 7-bit address 0x52
      new_case("R1 R3 R6 write");
      exp_ev(0, 0); exp_ev(2, bt(8'hA4, 0)); exp_ev(2, bt(8'h11, 0)); exp_ev(2, bt(8'h22, 0)); exp_ev(1, 0);
      push_cmd(11'h011); push_cmd(11'h222);
      end_case(0);

      // R2 R7: two reads with junk data fields
      new_case("R2 R7 read");
      sdat[0] = 8'hC3; sdat[1] = 8'h5A;
      erx[0] = 8'hC3; erx[1] = 8'h5A; ern = 2;
      exp_ev(0, 0); exp_ev(2, bt(8'hA5, 0)); exp_ev(2, bt(8'hC3, 0)); exp_ev(2, bt(8'h5A, 1)); exp_ev(1, 0);
      push_cmd(11'h1FF); push_cmd(11'h3AA);
      end_case(0);

      // R5: write then restarted read
      new_case("R5 restart");
      sdat[0] = 8'h96; erx[0] = 8'h96; ern = 1;
      exp_ev(0, 0); exp_ev(2, bt(8'hA4, 0)); exp_ev(2, bt(8'h77, 0));
      exp_ev(0, 0); exp_ev(2, bt(8'hA5, 0)); exp_ev(2, bt(8'h96, 1)); exp_ev(1, 0);
      push_cmd(11'h077); push_cmd(11'h700);
      end_case(0);

      // R4: 10-bit address 0x2B5
      new_case("R4 ten-bit");
      tgt_addr = 10'h2B5; addr_10b = 1'b1;
      exp_ev(0, 0); exp_ev(2, bt(8'hF4, 0)); exp_ev(2, bt(8'hB5, 0)); exp_ev(2, bt(8'hE1, 0)); exp_ev(1, 0);
      push_cmd(11'h2E1);
      end_case(0);
      tgt_addr = 10'h052; addr_10b = 1'b0;

      // R8: address NACK, two leftover commands discarded
      new_case("R8 addr nack");
      nack_at = 0;
      exp_ev(0, 0); exp_ev(2, bt(8'hA4, 1)); exp_ev(1, 0);
      push_cmd(11'h010); push_cmd(11'h020); push_cmd(11'h230);
      end_case(1);
      new_case("R8 after abort");
      exp_ev(0, 0); exp_ev(2, bt(8'hA4, 0)); exp_ev(2, bt(8'h55, 0)); exp_ev(1, 0);
      push_cmd(11'h255);
      end_case(0);

      // R8: data NACK
      new_case("R8 data nack");
      nack_at = 1;
      exp_ev(0, 0); exp_ev(2, bt(8'hA4, 0)); exp_ev(2, bt(8'h33, 1)); exp_ev(1, 0);
      push_cmd(11'h033); push_cmd(11'h244);
      end_case(1);

      // R9: starved queue keeps SCL low
      new_case("R9 stall");
      exp_ev(0, 0); exp_ev(2, bt(8'hA4, 0)); exp_ev(2, bt(8'h66, 0)); exp_ev(2, bt(8'h77, 0)); exp_ev(1, 0);
      push_cmd(11'h066);
      begin
         int lim = 0;
         bit quiet = 1'b1;
         int seen;
         while (oi < 3 && lim < 4000) begin
            @(negedge clk);
            lim++;
         end
         repeat (20) @(negedge clk);
         seen = oi;
         for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!scl_low || oi != seen || cmd_pop) quiet = 1'b0;
         end
         chk(quiet && seen == 3, "R9 SCL held low while queue empty", seen, 3);
      end
      push_cmd(11'h277);
      end_case(0);

      // R11: restart flag on the first command
      new_case("R11 first restart");
      exp_ev(0, 0); exp_ev(2, bt(8'hA4, 0)); exp_ev(2, bt(8'h88, 0)); exp_ev(1, 0);
      push_cmd(11'h688);
      end_case(0);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      nchk++;
      $display("FAIL watchdog %s act=timeout exp=finish", tag);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule